// File: doc/BRIEF.md
# Cascadable Up/Down Counter With Carries

A synchronous binary counter, four bits wide by default, that counts in either direction, loads a parallel value or clears on the rising clock edge. It drives its count onto a shared bus that can be released to high impedance. Two active-low enables gate counting. One enable, the parallel enable, only stops the count. The other, the trickle enable, also qualifies the ripple carry. This lets stages be chained into a wider counter without an extra gate.

The ripple carry is combinational and depends on direction: it falls at the all-ones count when counting up and at zero when counting down. A second, clocked carry repeats the ripple carry only while the stage is counting, and only during the low half of the clock. This gives a glitch-free strobe. An active-low asynchronous clear forces the count to zero at any time and overrides every other input.

Top module: `updn_cnt_casc`

## Requirements
- R1: While rst_ni is low the count is zero at once, with no clock edge, whatever the other inputs are.
- R2: sclr_ni low makes the count zero on the next rising edge, ahead of load and counting, and also when both enables are high.
- R3: With sclr_ni high and load_ni low, data_i is taken into the count on the next rising edge, whatever the enables are.
- R4: With sclr_ni and load_ni high and both cnt_par_ni and cnt_trk_ni low, each rising edge adds one when up_i is 1 and subtracts one when up_i is 0.
- R5: With sclr_ni and load_ni high and either enable high, the count holds.
- R6: Counting wraps modulo 2^WIDTH: all ones goes to zero going up, and zero goes to all ones going down.
- R7: rc_no is low exactly when cnt_trk_ni is low and the count is at its terminal value (all ones with up_i=1, zero with up_i=0). It follows cnt_trk_ni, up_i and the count without a clock edge, and cnt_par_ni has no effect on it.
- R8: cc_no is low only while clk_i is low, both enables are low and rc_no is low. At all other times it is high.
- R9: With oe_ni high, q_o is high impedance and the internal count keeps running. With oe_ni low, q_o shows the count.
- R10: Two instances sharing clock, cnt_par_ni, up_i and load_ni, with the lower rc_no driving the upper cnt_trk_ni, form a counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| data_i | input | WIDTH | Parallel load value |
| load_ni | input | 1 | Parallel load, active low |
| cnt_par_ni | input | 1 | Parallel count enable, active low |
| cnt_trk_ni | input | 1 | Trickle count enable, active low, also gates rc_no |
| up_i | input | 1 | Direction: 1 up, 0 down |
| sclr_ni | input | 1 | Synchronous clear, active low |
| oe_ni | input | 1 | Bus drive enable, active low |
| q_o | output | WIDTH | Count onto the bus, high impedance when released |
| rc_no | output | 1 | Ripple carry, active low |
| cc_no | output | 1 | Clocked carry, active low during clock-low phase |

## Verification
The bench builds every instance with WIDTH=4. At that width the wrap in both directions and both terminal counts are reached within a few cycles. Two such instances are chained into an eight-bit counter and swept through all 256 values upward and then downward. This exercises every carry handoff between the stages, including the upper stage's own terminal detection.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_CLR  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CNT  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_cnt_pkg::*;
(
  input  logic    sclr_ni,
  input  logic    load_ni,
  input  logic    cnt_par_ni,
  input  logic    cnt_trk_ni,
  output cnt_op_e op_o,
  output logic    cnt_en_o
);
  assign cnt_en_o = ~cnt_par_ni & ~cnt_trk_ni;

  // priority: clear, load, count, hold
  always_comb begin
    if (!sclr_ni)      op_o = OP_CLR;
    else if (!load_ni) op_o = OP_LOAD;
    else if (cnt_en_o) op_o = OP_CNT;
    else               op_o = OP_HOLD;
  end
endmodule

// File: rtl/updn_cnt_core.sv
module updn_cnt_core
  import updn_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic             up_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (op_i)
      OP_CLR:  cnt_d = '0;
      OP_LOAD: cnt_d = data_i;
      OP_CNT:  cnt_d = up_i ? cnt_q + ONE : cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/updn_carry.sv
module updn_carry #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             cnt_trk_ni,
  input  logic             cnt_en_i,
  output logic             rc_no,
  output logic             cc_no
);
  logic [WIDTH-1:0] term_bits;
  logic             at_term;

  // per-bit terminal match: all ones going up, all zeros going down
  for (genvar b = 0; b < WIDTH; b++) begin : g_term
    assign term_bits[b] = ~(cnt_i[b] ^ up_i);
  end

  assign at_term = &term_bits;
  assign rc_no   = ~(at_term & ~cnt_trk_ni);
  assign cc_no   = ~(cnt_en_i & ~rc_no & ~clk_i);

  always_comb begin
    if (rst_ni) begin
      AST_CC_NEEDS_RC: assert (cc_no || !rc_no); // R8
    end
  end
endmodule

// File: rtl/updn_cnt_casc.sv
module updn_cnt_casc
  import updn_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             load_ni,
  input  logic             cnt_par_ni,
  input  logic             cnt_trk_ni,
  input  logic             up_i,
  input  logic             sclr_ni,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             rc_no,
  output logic             cc_no
);
  localparam logic [WIDTH-1:0] MAX_CNT = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  cnt_op_e          op;
  logic             cnt_en;
  logic [WIDTH-1:0] cnt;

  updn_ctrl u_ctrl (
    .sclr_ni   (sclr_ni),
    .load_ni   (load_ni),
    .cnt_par_ni(cnt_par_ni),
    .cnt_trk_ni(cnt_trk_ni),
    .op_o      (op),
    .cnt_en_o  (cnt_en)
  );

  updn_cnt_core #(.WIDTH(WIDTH)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .up_i  (up_i),
    .data_i(data_i),
    .cnt_o (cnt)
  );

  updn_carry #(.WIDTH(WIDTH)) u_carry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .up_i      (up_i),
    .cnt_trk_ni(cnt_trk_ni),
    .cnt_en_i  (cnt_en),
    .rc_no     (rc_no),
    .cc_no     (cc_no)
  );

  assign q_o = oe_ni ? {WIDTH{1'bz}} : cnt;

  AST_SCLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclr_ni |=> cnt == '0); // R2
  AST_LOAD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_ni && !load_ni) |=> cnt == $past(data_i)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_ni && load_ni && !cnt_par_ni && !cnt_trk_ni)
      |=> cnt == ($past(up_i) ? $past(cnt) + ONE : $past(cnt) - ONE)); // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_ni && load_ni && (cnt_par_ni || cnt_trk_ni)) |=> $stable(cnt)); // R5
  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_ni && load_ni && !cnt_par_ni && !cnt_trk_ni && up_i && cnt == MAX_CNT)
      |=> cnt == '0); // R6
  AST_RC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_trk_ni |-> rc_no); // R7
endmodule

// File: tb/updn_cnt_casc_bench.sv
module updn_cnt_casc_bench;
  localparam int W = 4;
  localparam int NV = 12;
  // {req, sclr_n, load_n, par_n, trk_n, up, data, expected count}
  localparam logic [16:0] VEC [NV] = '{
    {4'd3,  5'b10111, 4'd5,  4'd5},
    {4'd4,  5'b11001, 4'd0,  4'd6},
    {4'd5,  5'b11101, 4'd0,  4'd6},
    {4'd5,  5'b11011, 4'd0,  4'd6},
    {4'd4,  5'b11000, 4'd0,  4'd5},
    {4'd3,  5'b10000, 4'd9,  4'd9},
    {4'd2,  5'b00000, 4'd3,  4'd0},
    {4'd6,  5'b11000, 4'd0,  4'd15},
    {4'd6,  5'b11001, 4'd0,  4'd0},
    {4'd3,  5'b10111, 4'd14, 4'd14},
    {4'd4,  5'b11001, 4'd0,  4'd15},
    {4'd2,  5'b01001, 4'd0,  4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] data = '0;
  logic load_n = 1'b1, par_n = 1'b1, trk_n = 1'b1, up = 1'b1, sclr_n = 1'b1, oe_n = 1'b0;
  wire  [W-1:0] q;
  wire  rc_n, cc_n;

  logic c_par_n = 1'b1, c_up = 1'b1, c_sclr_n = 1'b1;
  wire  [W-1:0] lo_q, hi_q;
  wire  lo_rc_n, lo_cc_n, hi_rc_n, hi_cc_n;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  updn_cnt_casc #(.WIDTH(W)) u_updn_cnt_casc (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .load_ni(load_n),
    .cnt_par_ni(par_n), .cnt_trk_ni(trk_n), .up_i(up), .sclr_ni(sclr_n),
    .oe_ni(oe_n), .q_o(q), .rc_no(rc_n), .cc_no(cc_n));

  // R10 cascade: lower rc drives upper trickle enable
  updn_cnt_casc #(.WIDTH(W)) u_updn_cnt_casc_lo (
    .clk_i(clk), .rst_ni(rst_n), .data_i('0), .load_ni(1'b1),
    .cnt_par_ni(c_par_n), .cnt_trk_ni(1'b0), .up_i(c_up), .sclr_ni(c_sclr_n),
    .oe_ni(1'b0), .q_o(lo_q), .rc_no(lo_rc_n), .cc_no(lo_cc_n));
  updn_cnt_casc #(.WIDTH(W)) u_updn_cnt_casc_hi (
    .clk_i(clk), .rst_ni(rst_n), .data_i('0), .load_ni(1'b1),
    .cnt_par_ni(c_par_n), .cnt_trk_ni(lo_rc_n), .up_i(c_up), .sclr_ni(c_sclr_n),
    .oe_ni(1'b0), .q_o(hi_q), .rc_no(hi_rc_n), .cc_no(hi_cc_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    #3;
    check(q == 4'd0, "R1 reset count", int'(q), 0);
    check(rc_n == 1'b1, "R7 rc under reset trk high", int'(rc_n), 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic exp_rc;
      {sclr_n, load_n, par_n, trk_n, up} = VEC[i][12:8];
      data = VEC[i][7:4];
      step();
      check(q == VEC[i][3:0], $sformatf("R%0d vector %0d count", VEC[i][16:13], i),
            int'(q), int'(VEC[i][3:0]));
      exp_rc = !(trk_n == 1'b0 && (up ? VEC[i][3:0] == 4'd15 : VEC[i][3:0] == 4'd0));
      check(rc_n == exp_rc, $sformatf("R7 vector %0d rc", i), int'(rc_n), int'(exp_rc));
    end

    // R7: combinational response, parallel enable irrelevant
    {sclr_n, load_n, par_n, trk_n, up} = 5'b10111;
    data = 4'd15;
    step();
    load_n = 1'b1; par_n = 1'b1; trk_n = 1'b0; up = 1'b1;
    #0.5;
    check(rc_n == 1'b0, "R7 rc at 15 up par high", int'(rc_n), 0);
    up = 1'b0;
    #0.5;
    check(rc_n == 1'b1, "R7 rc at 15 down", int'(rc_n), 1);
    up = 1'b1; trk_n = 1'b1;
    #0.5;
    check(rc_n == 1'b1, "R7 rc trk high", int'(rc_n), 1);
    trk_n = 1'b0;

    // R8: clocked carry
    @(negedge clk);
    #1;
    check(cc_n == 1'b1, "R8 cc high when par high", int'(cc_n), 1);
    @(negedge clk);
    par_n = 1'b0;
    #1;
    check(cc_n == 1'b0, "R8 cc low in clock-low phase", int'(cc_n), 0);
    @(posedge clk);
    #1;
    check(cc_n == 1'b1, "R8 cc high in clock-high phase", int'(cc_n), 1);
    check(q == 4'd0, "R6 wrap from 15 while counting", int'(q), 0);
    @(negedge clk);
    par_n = 1'b1;

    // R9: released bus, count keeps running
    load_n = 1'b0; data = 4'd3;
    step();
    load_n = 1'b1; par_n = 1'b0; trk_n = 1'b0; up = 1'b1; oe_n = 1'b1;
    step();
    step();
    par_n = 1'b1;
    #0.5;
    check((q === 4'bzzzz) || (q == 4'd0), "R9 bus released", int'(q), 0);
    oe_n = 1'b0;
    #0.5;
    check(q == 4'd5, "R9 count ran while released", int'(q), 5);

    // R1: async clear mid-cycle with load pending
    load_n = 1'b0; data = 4'd7;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(q == 4'd0, "R1 async clear immediate", int'(q), 0);
    @(posedge clk);
    #0.5;
    check(q == 4'd0, "R1 clear overrides load", int'(q), 0);
    @(negedge clk);
    rst_n = 1'b1; load_n = 1'b1;

    // R10: eight-bit cascade, full sweep up then down
    c_sclr_n = 1'b0;
    step();
    c_sclr_n = 1'b1;
    check({hi_q, lo_q} == 8'd0, "R10 cascade cleared", int'({hi_q, lo_q}), 0);
    c_par_n = 1'b0; c_up = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      step();
      check({hi_q, lo_q} == 8'(i), "R10 cascade up", int'({hi_q, lo_q}), i % 256);
      if (i == 255) check(hi_rc_n == 1'b0, "R10 upper rc at 255", int'(hi_rc_n), 0);
    end
    c_up = 1'b0;
    for (int i = 1; i <= 256; i++) begin
      step();
      check({hi_q, lo_q} == 8'(256 - i), "R10 cascade down", int'({hi_q, lo_q}), (256 - i) % 256);
      if (i == 256) check(hi_rc_n == 1'b0, "R10 upper rc at 0 down", int'(hi_rc_n), 0);
    end
    c_par_n = 1'b1;
    step();
    check({hi_q, lo_q} == 8'd0, "R5 cascade holds", int'({hi_q, lo_q}), 0);

    finish_run();
  end
endmodule